// File: doc/BRIEF.md
# Write-Once Time-Base Prescaler Control

This block is the configuration register for a serial bus interface. It is reached over a small register bus and holds three fields. The first is a two-bit divide-rate field that turns the input clock into the interface time base. The second is a clock-select flag that tells the symbol-timing logic whether the time base is nominally binary (1.048576 MHz) or integer (1 MHz). The third is an interrupt enable. The time base is a single-cycle enable pulse, `tick_en`, that fires once per divided period. When the divider is 1, `tick_en` stays high on every cycle.

The rate field seals itself after its first write following reset. A lock state machine has two states, `LK_OPEN` and `LK_SEALED`. It has one transition, `OPEN->SEALED`, taken on the first write to the control address. That transition captures the rate and restarts the divider counter. `LK_SEALED` has no exit other than reset. The clock-select and enable bits stay writable at all times.

Interrupt requests are level-sensitive: the request is the OR of all source lines. In run mode the enable gates the request. While the low-power indication is high, a pending source always drives the request, whatever the enable holds. A status address returns the raw OR of the sources, so software can poll instead of taking interrupts.

Top module: `tbase_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0, `binary_sel` is 0, `irq` is 0 and `tick_en` is high on every cycle, because the rate field resets to 0.
- R2: The rate field sits in control bits [1:0]. Rate 0, 1, 2 and 3 make `tick_en` high on exactly one cycle in every 1, 2, 4 and 8 cycles.
- R3: Only the first write to address 0 after reset loads the rate field. Later writes leave both its readback value and the tick period unchanged.
- R4: The divider restarts on that first write. Taking the first clock edge after the write edge as cycle 0, `tick_en` is high on cycle k exactly when k mod N equals N-1.
- R5: Control bit 2 is the clock-select flag. It is writable on every write to address 0, reads back, and drives `binary_sel` (1 means binary, 0 means integer).
- R6: Control bit 3 is the interrupt enable. With `lp_mode` at 0, `irq` equals the OR of `irq_src` ANDed with the enable.
- R7: With `lp_mode` at 1, `irq` equals the OR of `irq_src`, whatever the enable holds.
- R8: `irq` stays high for as long as any source stays high. It falls only once every source is clear.
- R9: Clearing the enable masks a pending request from the edge at which the write takes effect. A masked request is not stored: after the sources clear and the enable is set again, `irq` stays low.
- R10: Address 1 reads the OR of `irq_src` in bit 0, with all other bits 0, whatever the enable holds.
- R11: Writes to any address other than 0 change no field and do not seal the rate field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that is divided |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address (0 control, 1 status) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational on the address |
| irq_src | input | NSRC | Level interrupt source lines |
| lp_mode | input | 1 | High while in stop or wait mode (wakeup path) |
| tick_en | output | 1 | Time-base clock-enable pulse |
| binary_sel | output | 1 | Clock-select flag for symbol timing |
| irq | output | 1 | Gated interrupt request |

## Verification
A lock machine stuck in the open state would let a second control write change the rate readback on the very next cycle. It would also move the tick phase, because each accepted write restarts the divider. A lock machine that sealed early, for example on an unmapped write, would show up as the first real write being ignored. A wrong divider count or restart shows up within one divided period, at most eight cycles, as a `tick_en` high on the wrong cycle index. Errors in the enable or low-power gating show up on `irq` in the same cycle as the input change.

// File: rtl/tbctl_pkg.sv
package tbctl_pkg;
    localparam int CTRL_ADDR = 0;
    localparam int STAT_ADDR = 1;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;
endpackage

// File: rtl/tb_rate_lock.sv
module tb_rate_lock
    import tbctl_pkg::*;
#(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [RATE_W-1:0] wr_rate,
    output logic [RATE_W-1:0] rate_q,
    output logic              restart,
    output logic              sealed
);
    lock_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= LK_OPEN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        unique case (st_q)
            LK_OPEN: begin
                if (wr_ctrl) begin
                    st_d    = LK_SEALED;
                    restart = 1'b1;
                end
            end
            LK_SEALED: begin
                st_d = LK_SEALED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
        end else if (restart) begin
            rate_q <= wr_rate;
        end
    end

    assign sealed = (st_q == LK_SEALED);
endmodule

// File: rtl/tb_divider.sv
module tb_divider #(
    parameter int RATE_W = 2,
    localparam int CNT_W = (1 << RATE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim = CNT_W'((32'd1 << rate) - 32'd1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (cnt_q >= lim) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == lim);
endmodule

// File: rtl/tb_irq_gate.sv
module tb_irq_gate #(
    parameter int NSRC = 4
) (
    input  logic [NSRC-1:0] src,
    input  logic            ie,
    input  logic            lp_mode,
    output logic            pend,
    output logic            irq
);
    always_comb begin
        pend = |src;
        irq  = pend & (ie | lp_mode);
    end
endmodule

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
    import tbctl_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8,
    parameter int NSRC   = 4,
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   irq_src,
    input  logic              lp_mode,
    output logic              tick_en,
    output logic              binary_sel,
    output logic              irq
);
    localparam int CKSEL_BIT = RATE_W;
    localparam int IE_BIT    = RATE_W + 1;

    logic              wr_ctrl;
    logic              cksel_q;
    logic              ie_q;
    logic [RATE_W-1:0] rate_q;
    logic              restart;
    logic              sealed;
    logic              pend;
    logic              unused_wbits;

    assign wr_ctrl      = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
    assign unused_wbits = ^bus_wdata[DATA_W-1:IE_BIT+1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cksel_q <= 1'b0;
            ie_q    <= 1'b0;
        end else if (wr_ctrl) begin
            cksel_q <= bus_wdata[CKSEL_BIT];
            ie_q    <= bus_wdata[IE_BIT];
        end
    end

    tb_rate_lock #(.RATE_W(RATE_W)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_rate (bus_wdata[RATE_W-1:0]),
        .rate_q  (rate_q),
        .restart (restart),
        .sealed  (sealed)
    );

    tb_divider #(.RATE_W(RATE_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .rate    (rate_q),
        .tick    (tick_en)
    );

    tb_irq_gate #(.NSRC(NSRC)) u_gate (
        .src     (irq_src),
        .ie      (ie_q),
        .lp_mode (lp_mode),
        .pend    (pend),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
            bus_rdata[RATE_W-1:0] = rate_q;
            bus_rdata[CKSEL_BIT]  = cksel_q;
            bus_rdata[IE_BIT]     = ie_q;
        end else if (bus_addr == ADDR_W'(STAT_ADDR)) begin
            bus_rdata[0] = pend;
        end
    end

    assign binary_sel = cksel_q;
endmodule

// File: rtl/tbase_ctrl_chk.sv
module tbase_ctrl_chk #(
    parameter int NSRC   = 4,
    parameter int RATE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   irq_src,
    input logic              lp_mode,
    input logic              irq,
    input logic              ie_q,
    input logic [RATE_W-1:0] rate_q,
    input logic              sealed,
    input logic              tick_en
);
    // R3
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> $stable(rate_q) && sealed);

    // R2
    div_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_q == '0) |-> tick_en);

    // R6
    run_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_mode && !ie_q) |-> !irq);

    // R7
    wake_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode && (irq_src != '0)) |-> irq);

    // R8
    src_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_src != '0));
endmodule

bind tbase_ctrl tbase_ctrl_chk #(.NSRC(NSRC), .RATE_W(RATE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_src (irq_src),
    .lp_mode (lp_mode),
    .irq     (irq),
    .ie_q    (ie_q),
    .rate_q  (rate_q),
    .sealed  (sealed),
    .tick_en (tick_en)
);

// File: tb/sim_tbase_ctrl.sv
module sim_tbase_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] irq_src = '0;
    logic       lp_mode = 1'b0;
    logic       tick_en, binary_sel, irq;

    int n_chk = 0;
    int n_bad = 0;
    int idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbase_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
        .lp_mode(lp_mode), .tick_en(tick_en), .binary_sel(binary_sel), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_wr = 1'b0;
        irq_src = '0;
        lp_mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v;
        for (int r = 0; r < 4; r++) begin
            int div;
            div = 1 << r;
            do_reset();
            // R1 reset state
            rd(2'd0, v);
            check("R1 ctrl", v, 0);
            check("R1 binary_sel", int'(binary_sel), 0);
            check("R1 irq", int'(irq), 0);
            for (int k = 0; k < 3; k++) begin
                check("R1 tick", int'(tick_en), 1);
                @(negedge clk);
            end
            // R11 unmapped and status writes leave everything open
            wr(2'd2, 8'hFF);
            wr(2'd1, 8'hFF);
            wr(2'd3, 8'hFF);
            rd(2'd0, v);
            check("R11 ctrl", v, 0);
            // R2 R4 first write, period and phase
            wr(2'd0, 8'(r));
            idx = 0;
            for (int k = 0; k < 16; k++) begin
                check("R2 R4 tick", int'(tick_en), ((idx % div) == div - 1) ? 1 : 0);
                if (k != 15) begin
                    @(negedge clk);
                    idx++;
                end
            end
            // R3 second write ignored for rate, R5 clock select updates
            wr(2'd0, 8'h04 | 8'(3 - r));
            idx += 2;
            rd(2'd0, v);
            check("R3 R5 readback", v, 4 | r);
            check("R5 binary_sel", int'(binary_sel), 1);
            for (int k = 0; k < 16; k++) begin
                check("R3 tick", int'(tick_en), ((idx % div) == div - 1) ? 1 : 0);
                @(negedge clk);
                idx++;
            end
            wr(2'd0, 8'h00 | 8'(3 - r));
            rd(2'd0, v);
            check("R5 clear", v, r);
            check("R5 binary_sel0", int'(binary_sel), 0);
        end

        // R6 R7 R10 sweep
        do_reset();
        for (int e = 0; e < 2; e++) begin
            wr(2'd0, e[0] ? 8'h08 : 8'h00);
            for (int l = 0; l < 2; l++) begin
                for (int s = 0; s < 16; s++) begin
                    irq_src = 4'(s);
                    lp_mode = l[0];
                    #1;
                    check(l[0] ? "R7 irq" : "R6 irq", int'(irq),
                          ((s != 0) && (e[0] || l[0])) ? 1 : 0);
                    rd(2'd1, v);
                    check("R10 status", v, (s != 0) ? 1 : 0);
                end
            end
        end
        irq_src = '0;
        lp_mode = 1'b0;

        // R9 immediate mask, no stored delivery
        wr(2'd0, 8'h08);
        irq_src = 4'b0010;
        #1;
        check("R9 pre", int'(irq), 1);
        wr(2'd0, 8'h00);
        check("R9 masked", int'(irq), 0);
        irq_src = '0;
        wr(2'd0, 8'h08);
        check("R9 not stored", int'(irq), 0);

        // R8 level hold
        irq_src = 4'b1001;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 hold", int'(irq), 1);
        end
        irq_src = 4'b1000;
        @(negedge clk);
        check("R8 partial", int'(irq), 1);
        irq_src = '0;
        @(negedge clk);
        check("R8 clear", int'(irq), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule